// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (256 x 8)

This block is the digital slave of a 256-byte serial memory on a two-wire bus. The SCL and SDA lines are sampled by the system clock through a short synchronizer. A START is a falling SDA edge while SCL is high, and a STOP is a rising SDA edge while SCL is high. The first byte after a START is a select byte, sent MSB first. It must carry the device code 1010 in bits 7..4 and the three strap inputs in bits 3..1. Bit 0 is the direction: 0 for write, 1 for read. The slave acknowledges a byte by driving an open-drain enable that pulls SDA low during the ninth clock.

In a write, the first byte after the select is the memory address. Data bytes follow it and are collected in a small buffer. The buffer accepts 4 bytes when the mode pin is high and 8 bytes when it is low. A STOP starts a timed commit of the buffered bytes into the array at consecutive addresses, unless the protect pin is high at that STOP. During the commit, the busy output is high and the bus is ignored.

A read returns the byte at the internal pointer. The pointer then advances by one and wraps from 255 to 0. The master can set the pointer first with a dummy write of the address, followed by a repeated START; this is a random read. The read continues byte after byte while the master acknowledges each one.

The control state machine has the following states:
- ST_IDLE: standby.
- ST_SEL / ST_SELACK: receive the select byte, then acknowledge it.
- ST_ADDR / ST_ADDRACK: receive the address byte, then acknowledge it.
- ST_WDATA / ST_WACK: receive a data byte, then acknowledge it (or not).
- ST_RDATA / ST_RACK: shift out a read byte, then sample the master's acknowledge.

Its transitions are:
- START: any state goes to ST_SEL.
- STOP: any state goes to ST_IDLE. The commit starts only when the STOP arrives in ST_WDATA or ST_WACK.
- Select match: ST_SEL goes to ST_SELACK.
- Select mismatch: ST_SEL goes to ST_IDLE.
- Read direction: ST_SELACK goes to ST_RDATA.
- Write direction: ST_SELACK goes to ST_ADDR.
- Write path: ST_ADDR goes to ST_ADDRACK, then to ST_WDATA. ST_WDATA and ST_WACK then alternate.
- Read path: ST_RDATA goes to ST_RACK. ST_RACK goes back to ST_RDATA on a master acknowledge and to ST_IDLE on a no-acknowledge.
- Busy: any state goes to ST_IDLE while busy is high.

Top module: `serial_eeprom_slave`

## Requirements
- R1: Only a select byte whose bits 7..4 are 1010 and whose bits 3..1 equal the strap inputs (MSB first) is acknowledged. A mismatching select byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: The slave acknowledges by pulling SDA low (sda_oe_o=1) through the ninth SCL clock. It changes SDA only after a falling SCL edge.
- R3: A write of one address byte, then data bytes, then a STOP stores the data at consecutive addresses starting at that address. A later read returns the stored data.
- R4: With wmode_i=1, the first 4 data bytes are acknowledged and stored. With wmode_i=0, the first 8 are. Further bytes get no acknowledge and are dropped.
- R5: The commit starts only on a STOP. A START that arrives before the STOP discards the buffered data.
- R6: If wprot_i=1 at the STOP, nothing is committed, busy_o stays low and the array is unchanged.
- R7: After a committing STOP, busy_o is high for exactly PROG_CYCLES clocks. During that time, a select byte is not acknowledged.
- R8: A random read (dummy write of the address, repeated START, select byte with bit 0 = 1) returns the byte at that address.
- R9: After reset, the array holds zeros and the pointer is 0. The pointer advances by one for each acknowledged data byte and each byte read, and wraps from 255 to 0. A current-address read (select byte with bit 0 = 1 only) returns the byte at the pointer.
- R10: A sequential read continues with the next byte while the master acknowledges. After a master no-acknowledge, the slave releases SDA and returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line as seen on the wire, sampled |
| chip_sel_i | input | 3 | Strap inputs compared with select bits 3..1 |
| wmode_i | input | 1 | 1: 4-byte write buffer, 0: 8-byte write buffer |
| wprot_i | input | 1 | 1: commits are blocked |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The bit counter or the state register can slip by one position. Such a fault appears within the same byte: the acknowledge lands on the wrong clock, or the read bits are shifted. The bench samples every ninth bit and every read bit, so it sees this at once. A wrong pointer or buffer count does not show until a later read returns bytes from the wrong address. A timer fault shows as a busy pulse of the wrong length, or as an acknowledge during programming. Random write and read-back rounds, compared with a bench memory model, expose the delayed faults.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned MEM_DEPTH = 1 << ADDR_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SELACK,
        ST_ADDR,
        ST_ADDRACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_state_t;
endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_p;
    logic [SYNC_STAGES-1:0] sda_p;
    logic scl_q;
    logic sda_q;
    logic scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-2:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_p[SYNC_STAGES-1];
    assign sda_s     = sda_p[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edge while SCL held high on both samples
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_commit_engine.sv
module eep_commit_engine
    import eep_pkg::*;
#(
    parameter int unsigned MB_DEPTH    = 4,
    parameter int unsigned PG_DEPTH    = 8,
    parameter int unsigned PROG_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wmode,
    input  logic              clear,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic              commit_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              full,
    output logic              has_data,
    output logic              busy
);
    localparam int unsigned CW = $clog2(PG_DEPTH + 1);
    localparam int unsigned IW = $clog2(PG_DEPTH);
    localparam int unsigned TW = $clog2(PROG_CYCLES + 1);

    logic [7:0]        mem  [MEM_DEPTH];
    logic [7:0]        wbuf [PG_DEPTH];
    logic [CW-1:0]     wcnt;
    logic [CW-1:0]     cap;
    logic [ADDR_W-1:0] wbase;
    logic [TW-1:0]     tmr;
    logic              done;

    assign cap      = wmode ? CW'(MB_DEPTH) : CW'(PG_DEPTH);
    assign full     = (wcnt >= cap);
    assign has_data = (wcnt != '0);
    assign done     = busy && (tmr == '0);
    assign rd_data  = mem[rd_addr];

    // write buffer and base address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt  <= '0;
            wbase <= '0;
            for (int i = 0; i < int'(PG_DEPTH); i++) wbuf[i] <= 8'h00;
        end else begin
            if (base_load) wbase <= base_addr;
            if (clear || done) begin
                wcnt <= '0;
            end else if (push && !full) begin
                wbuf[wcnt[IW-1:0]] <= push_data;
                wcnt               <= wcnt + 1'b1;
            end
        end
    end

    // programming timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (commit_req && !busy) begin
            busy <= 1'b1;
            tmr  <= TW'(PROG_CYCLES - 1);
        end else if (busy) begin
            if (tmr == '0) busy <= 1'b0;
            else           tmr  <= tmr - 1'b1;
        end
    end

    // array, written at the end of the programming time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MEM_DEPTH); i++) mem[i] <= 8'h00;
        end else if (done) begin
            for (int i = 0; i < int'(PG_DEPTH); i++)
                if (CW'(i) < wcnt) mem[wbase + ADDR_W'(i)] <= wbuf[i];
        end
    end

    p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_bus_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!push && !base_load && !commit_req));
endmodule

// File: rtl/eep_proto_fsm.sv
module eep_proto_fsm
    import eep_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        chip_sel,
    input  logic              wprot,
    input  logic              busy,
    input  logic              full,
    input  logic              has_data,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              clear,
    output logic              base_load,
    output logic              push,
    output logic [7:0]        push_data,
    output logic              commit_req,
    output logic              sda_low
);
    bus_state_t state, state_n;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] out_sh;
    logic       rw;
    logic       wack;
    logic       mack;
    logic       ld_rd;
    logic       rx_state;
    logic       in_wr;
    logic       sel_match;

    assign rx_state  = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_WDATA);
    assign in_wr     = (state == ST_WDATA) || (state == ST_WACK);
    assign sel_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_sel);
    assign push_data = shreg;

    // next state and strobes
    always_comb begin
        state_n    = state;
        push       = 1'b0;
        clear      = 1'b0;
        commit_req = 1'b0;
        base_load  = 1'b0;
        ld_rd      = 1'b0;
        if (busy) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_SEL;
            clear   = 1'b1;
        end else if (stop_det) begin
            state_n    = ST_IDLE;
            commit_req = in_wr && !wprot && has_data;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_SEL:
                    if (scl_fall && cnt == 4'd8) state_n = sel_match ? ST_SELACK : ST_IDLE;
                ST_SELACK:
                    if (scl_fall) begin
                        if (rw) begin
                            state_n = ST_RDATA;
                            ld_rd   = 1'b1;
                        end else begin
                            state_n = ST_ADDR;
                        end
                    end
                ST_ADDR:
                    if (scl_fall && cnt == 4'd8) begin
                        state_n   = ST_ADDRACK;
                        base_load = 1'b1;
                    end
                ST_ADDRACK:
                    if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && cnt == 4'd8) begin
                        state_n = ST_WACK;
                        push    = !full;
                    end
                ST_WACK:
                    if (scl_fall) state_n = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && cnt == 4'd7) state_n = ST_RACK;
                ST_RACK:
                    if (scl_fall) begin
                        if (mack) begin
                            state_n = ST_RDATA;
                            ld_rd   = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            shreg  <= '0;
            out_sh <= '0;
            rw     <= 1'b0;
            wack   <= 1'b0;
            mack   <= 1'b0;
            ptr    <= '0;
        end else begin
            if (state_n != state || start_det)
                cnt <= '0;
            else if (rx_state && scl_rise && cnt != 4'd8)
                cnt <= cnt + 4'd1;
            else if (state == ST_RDATA && scl_fall)
                cnt <= cnt + 4'd1;

            if (rx_state && scl_rise) shreg <= {shreg[6:0], sda_s};
            if (state == ST_SEL && state_n == ST_SELACK) rw <= shreg[0];
            if (state == ST_WDATA && state_n == ST_WACK) wack <= !full;
            if (state == ST_RACK && scl_rise) mack <= !sda_s;

            if (base_load)          ptr <= shreg[ADDR_W-1:0];
            else if (push || ld_rd) ptr <= ptr + 1'b1;

            if (ld_rd)                              out_sh <= rd_data;
            else if (state == ST_RDATA && scl_fall) out_sh <= {out_sh[6:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SELACK, ST_ADDRACK: sda_low = 1'b1;
            ST_WACK:               sda_low = wack;
            ST_RDATA:              sda_low = !out_sh[7];
            default:               sda_low = 1'b0;
        endcase
    end

    p_drive_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> $past(scl_fall));
    p_start_to_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> (state == ST_SEL && !sda_low));
    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_low);
    p_quiet_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eep_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MB_DEPTH    = 4,
    parameter int unsigned PG_DEPTH    = 8,
    parameter int unsigned PROG_CYCLES = 5000,
    parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wmode_i,
    input  logic       wprot_i,
    output logic       sda_oe_o,
    output logic       busy_o
);
    logic scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic clear, base_load, push, commit_req, full, has_data;
    logic [7:0]        push_data, rd_data;
    logic [ADDR_W-1:0] ptr;

    eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_proto_fsm #(.DEV_CODE(DEV_CODE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .chip_sel(chip_sel_i), .wprot(wprot_i), .busy(busy_o), .full(full),
        .has_data(has_data), .rd_data(rd_data), .ptr(ptr), .clear(clear),
        .base_load(base_load), .push(push), .push_data(push_data),
        .commit_req(commit_req), .sda_low(sda_oe_o)
    );

    eep_commit_engine #(
        .MB_DEPTH(MB_DEPTH), .PG_DEPTH(PG_DEPTH), .PROG_CYCLES(PROG_CYCLES)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .wmode(wmode_i), .clear(clear),
        .base_load(base_load), .base_addr(push_data), .push(push),
        .push_data(push_data), .commit_req(commit_req), .rd_addr(ptr),
        .rd_data(rd_data), .full(full), .has_data(has_data), .busy(busy_o)
    );
endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
    localparam int PROG  = 400;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wmode = 1'b1;
    logic wprot = 1'b0;
    logic sda_oe, busy;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;
    always #2.5 clk = ~clk;

    serial_eeprom_slave #(.PROG_CYCLES(PROG)) u_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .chip_sel_i(STRAP), .wmode_i(wmode), .wprot_i(wprot),
        .sda_oe_o(sda_oe), .busy_o(busy)
    );

    int nchk = 0;
    int nerr = 0;
    bit [7:0] model [256];
    int mptr = 0;
    bit [7:0] pay [16];
    int run_len = 0;
    int last_len = 0;

    always @(posedge clk) begin
        if (busy) run_len++;
        else if (run_len != 0) begin
            last_len = run_len;
            run_len = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit [7:0] dsel(bit rd);
        return {4'b1010, STRAP, rd};
    endfunction

    function automatic int cap_of(bit md);
        return md ? 4 : 8;
    endfunction

    task automatic bus_start();
        scl_m = 1'b0; sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b0; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic clk_bit(input bit b, output bit r);
        sda_m = b; tick(4);
        scl_m = 1'b1; tick(4);
        r = sda_line; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic send_byte(input bit [7:0] b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit mack, output bit [7:0] d);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            d[i] = r;
        end
        clk_bit(!mack, r);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 10000) begin
            tick(1);
            guard++;
        end
    endtask

    task automatic write_burst(input bit [7:0] a, input int n, input bit md, input string tag);
        bit ack;
        int acc;
        wmode = md;
        bus_start();
        send_byte(dsel(1'b0), ack); chk(tag, ack, 1);
        send_byte(a, ack);          chk(tag, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(pay[i], ack);
            chk(tag, ack, (i < cap_of(md)) ? 1 : 0);
        end
        bus_stop();
        acc = (n < cap_of(md)) ? n : cap_of(md);
        if (!wprot) for (int i = 0; i < acc; i++) model[8'(int'(a) + i)] = pay[i];
        mptr = (int'(a) + acc) % 256;
        tick(4);
        wait_idle();
        tick(4);
    endtask

    task automatic read_tail(input int n, input string tag);
        bit [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(tag, d, model[8'(mptr + i)]);
        end
        chk(tag, sda_oe, 0);
        bus_stop();
        mptr = (mptr + n) % 256;
    endtask

    task automatic rand_read(input bit [7:0] a, input int n, input string tag);
        bit ack;
        bus_start();
        send_byte(dsel(1'b0), ack); chk(tag, ack, 1);
        send_byte(a, ack);          chk(tag, ack, 1);
        bus_start();
        send_byte(dsel(1'b1), ack); chk(tag, ack, 1);
        mptr = a;
        read_tail(n, tag);
    endtask

    task automatic cur_read(input int n, input string tag);
        bit ack;
        bus_start();
        send_byte(dsel(1'b1), ack); chk(tag, ack, 1);
        read_tail(n, tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        bit ack;
        bit [7:0] a;
        bit md;
        int n;
        void'($urandom(32'h1F2E3D4C));
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9: reset state
        chk("R9 reset sda", sda_oe, 0);
        chk("R7 reset busy", busy, 0);
        cur_read(2, "R9 reset array/pointer");

        // R1: wrong straps, then wrong device code
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack); chk("R1 strap mismatch", ack, 0);
        send_byte(8'h00, ack);                   chk("R1 ignored after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);  chk("R1 code mismatch", ack, 0);
        bus_stop();
        tick(4);
        chk("R1 no busy after mismatch", busy, 0);

        // R3 / R7: byte write, busy length, no ack during programming
        pay[0] = 8'hA5;
        wmode = 1'b1;
        bus_start();
        send_byte(dsel(1'b0), ack); chk("R2 select ack", ack, 1);
        send_byte(8'h10, ack);      chk("R2 address ack", ack, 1);
        send_byte(8'hA5, ack);      chk("R2 data ack", ack, 1);
        bus_stop();
        model[8'h10] = 8'hA5;
        mptr = 8'h11;
        tick(2);
        chk("R7 busy after stop", busy, 1);
        bus_start();
        send_byte(dsel(1'b1), ack); chk("R7 no ack while busy", ack, 0);
        bus_stop();
        wait_idle();
        tick(4);
        chk("R7 busy length", last_len, PROG);
        rand_read(8'h10, 1, "R3 R8 byte write readback");

        // R4: 4-byte mode, 5 bytes sent
        for (int i = 0; i < 16; i++) pay[i] = 8'(8'h30 + i);
        write_burst(8'h20, 5, 1'b1, "R4 multibyte");
        rand_read(8'h20, 5, "R4 multibyte readback");

        // R4: 8-byte mode, 9 bytes sent
        write_burst(8'h40, 9, 1'b0, "R4 page");
        rand_read(8'h40, 9, "R4 page readback");

        // R5: START before STOP drops buffered data
        wmode = 1'b0;
        bus_start();
        send_byte(dsel(1'b0), ack); chk("R5 select", ack, 1);
        send_byte(8'h60, ack);      chk("R5 address", ack, 1);
        send_byte(8'h77, ack);      chk("R5 data", ack, 1);
        send_byte(8'h78, ack);      chk("R5 data", ack, 1);
        bus_start();
        bus_stop();
        tick(4);
        chk("R5 no commit after restart", busy, 0);
        rand_read(8'h60, 2, "R5 array unchanged");

        // R6: protect blocks the commit
        wprot = 1'b1;
        pay[0] = 8'hEE; pay[1] = 8'hDD;
        write_burst(8'h70, 2, 1'b0, "R6 protected write");
        chk("R6 busy stays low", busy, 0);
        wprot = 1'b0;
        rand_read(8'h70, 2, "R6 readback unchanged");

        // R9: current address after write and wrap 255 -> 0
        pay[0] = 8'h5A;
        write_burst(8'h80, 1, 1'b1, "R9 seed");
        pay[0] = 8'h11; pay[1] = 8'h22;
        write_burst(8'h7E, 2, 1'b1, "R9 write before current read");
        cur_read(1, "R9 current address after write");
        pay[0] = 8'hC3; pay[1] = 8'h3C;
        write_burst(8'hFF, 2, 1'b0, "R9 write across wrap");
        rand_read(8'hFF, 3, "R9 R10 sequential wrap read");
        cur_read(1, "R9 pointer after wrap read");

        // Random rounds
        for (int k = 0; k < 8; k++) begin
            a  = 8'($urandom % 256);
            md = 1'($urandom % 2);
            n  = 1 + int'($urandom % (cap_of(md) + 1));
            for (int i = 0; i < 16; i++) pay[i] = 8'($urandom);
            write_burst(a, n, md, "R3 R4 random write");
            rand_read(a, (n < cap_of(md)) ? n : cap_of(md), "R8 R10 random read");
            cur_read(2, "R9 R10 random current read");
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule